// File: doc/BRIEF.md
# Flash Access Security Gate

This block stands in front of a flash memory controller and decides which flash commands may reach it. Two requesters share it: the on-chip processor and the debug port. Each sends single-cycle command pulses carrying an operation code (program a location, erase one page, or erase the whole array) and an address. A lock bit, which software can set but never clear, switches the gate from open to protected.

While the lock is set, the lowest page of the array is shielded, because it holds the boot code that runs before the application. Programming and page erase aimed at it are refused, whichever requester sends them. The debug port is held to whole-array erase only. A whole-array erase is always allowed. When it completes, the array is blank, so the lock drops. Every command gets exactly one answer. A grant forwards it to the controller as a start pulse. A reject raises a sticky violation flag for the source that sent it.

Only one controller operation runs at a time. Commands that arrive while one is busy, or that lose the same-cycle arbitration to the processor, are held in a per-source slot and answered in order once the controller reports done.

Top module: `flash_sec_gate`

## Requirements
- R1: With the lock clear, every request with op 00 (program), 01 (page erase) or 10 (whole erase) from either source is granted. When the gate is idle, the grant appears in the cycle after the valid pulse.
- R2: With the lock set, a debug-port request with op 00 or 01 is rejected at any address.
- R3: With the lock set, a program request (op 00) to page zero is rejected from either source. The processor may still program any other page.
- R4: With the lock set, a page erase (op 01) of page zero is rejected from either source. A processor page erase of any other page is granted.
- R5: A whole-array erase (op 10) is granted from either source in both lock states. When the controller's done pulse ends such an erase, the lock is clear in the following cycle.
- R6: The lock is clear after reset. A pulse on `lock_set` makes it read 1 in the next cycle, and it stays 1 until reset or R5 clears it.
- R7: An address is in page zero exactly when all bits above the page offset are zero. Address PAGE_BYTES-1 is in page zero, and address PAGE_BYTES is not.
- R8: Each request receives exactly one of grant or reject. A reject sets that source's violation flag, which stays set until reset.
- R9: When both sources pulse valid in the same cycle, the processor is answered first. The debug request is held and answered later with its own op and address.
- R10: While a granted operation is busy, no request is answered. A held request is answered in the second cycle after the `fc_done` pulse.
- R11: Op code 11 is reserved and is rejected in both lock states.
- R12: A grant raises `fc_start` for exactly one cycle, in the same cycle as the grant. `fc_op` and `fc_addr` carry the granted request's op and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_set | input | 1 | Pulse to set the lock bit |
| cpu_valid | input | 1 | Processor request pulse |
| cpu_op | input | 2 | Processor op code |
| cpu_addr | input | ADDR_W | Processor byte address |
| dbg_valid | input | 1 | Debug-port request pulse |
| dbg_op | input | 2 | Debug-port op code |
| dbg_addr | input | ADDR_W | Debug-port byte address |
| cpu_grant | output | 1 | Processor request granted |
| cpu_reject | output | 1 | Processor request refused |
| dbg_grant | output | 1 | Debug request granted |
| dbg_reject | output | 1 | Debug request refused |
| cpu_viol | output | 1 | Sticky processor violation flag |
| dbg_viol | output | 1 | Sticky debug violation flag |
| locked | output | 1 | Current lock bit |
| fc_start | output | 1 | Start pulse to the flash controller |
| fc_op | output | 2 | Op code forwarded to the controller |
| fc_addr | output | ADDR_W | Address forwarded to the controller |
| fc_done | input | 1 | Controller reports the current operation finished |

## Verification
The assertions assume that a source pulses valid only when it has no unanswered request of its own. They also assume that `fc_done` is a single pulse that arrives only while a granted operation is outstanding. The bench keeps to both. It waits for each answer before sending the next request from that source, and it raises `fc_done` for one cycle only after it has observed `fc_start`. The exhaustive sweep covers every combination of lock state, source, op code and boundary address. Each trial starts from reset, so the flag and lock checks do not depend on earlier trials.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
package fsg_pkg;
  typedef enum logic [1:0] {
    OP_PROG  = 2'b00,
    OP_PERASE = 2'b01,
    OP_WHOLE = 2'b10,
    OP_RSVD  = 2'b11
  } fop_e;

  localparam int NSRC = 2;
  localparam int SRC_CPU = 0;
  localparam int SRC_DBG = 1;
endpackage

// File: rtl/fsg_hold.sv
`timescale 1ns/1ps
// One-entry holding slot per source: passes a fresh request straight
// through, keeps it when it is not served in that cycle.
module fsg_hold #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    in_op,
  input  logic [AW-1:0] in_addr,
  input  logic          take,
  output logic          out_valid,
  output logic [1:0]    out_op,
  output logic [AW-1:0] out_addr
);
  logic          slot_v;
  logic [1:0]    slot_op;
  logic [AW-1:0] slot_addr;

  always_comb begin
    out_valid = slot_v | in_valid;
    out_op    = slot_v ? slot_op   : in_op;
    out_addr  = slot_v ? slot_addr : in_addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_v    <= 1'b0;
      slot_op   <= '0;
      slot_addr <= '0;
    end else begin
      slot_v    <= out_valid & ~take;
      slot_op   <= out_op;
      slot_addr <= out_addr;
    end
  end
endmodule

// File: rtl/fsg_rule.sv
`timescale 1ns/1ps
// Permission rule for one source.
module fsg_rule #(
  parameter int PW = 6,
  parameter bit IS_DBG = 1'b0
) (
  input  logic          locked,
  input  logic [1:0]    op,
  input  logic [PW-1:0] page,
  output logic          allow
);
  import fsg_pkg::*;
  logic page0;
  logic shielded_op;

  always_comb begin
    page0       = (page == '0);
    shielded_op = (op == OP_PROG) || (op == OP_PERASE);
    if (op == OP_RSVD)
      allow = 1'b0;
    else if (!locked)
      allow = 1'b1;
    else if (IS_DBG)
      allow = (op == OP_WHOLE);
    else
      allow = !(page0 && shielded_op);
  end
endmodule

// File: rtl/fsg_lock.sv
`timescale 1ns/1ps
// Set-only lock bit; cleared by reset or a finished whole-array erase.
module fsg_lock (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic wipe_done,
  output logic locked
);
  always_ff @(posedge clk) begin
    if (rst)
      locked <= 1'b0;
    else if (set_req)
      locked <= 1'b1;
    else if (wipe_done)
      locked <= 1'b0;
  end
endmodule

// File: rtl/flash_sec_gate.sv
`timescale 1ns/1ps
module flash_sec_gate #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_set,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              dbg_valid,
  input  logic [1:0]        dbg_op,
  input  logic [ADDR_W-1:0] dbg_addr,
  output logic              cpu_grant,
  output logic              cpu_reject,
  output logic              dbg_grant,
  output logic              dbg_reject,
  output logic              cpu_viol,
  output logic              dbg_viol,
  output logic              locked,
  output logic              fc_start,
  output logic [1:0]        fc_op,
  output logic [ADDR_W-1:0] fc_addr,
  input  logic              fc_done
);
  import fsg_pkg::*;

  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFS_W;

  logic [NSRC-1:0]             in_v;
  logic [NSRC-1:0][1:0]        in_op;
  logic [NSRC-1:0][ADDR_W-1:0] in_addr;
  logic [NSRC-1:0]             h_v;
  logic [NSRC-1:0][1:0]        h_op;
  logic [NSRC-1:0][ADDR_W-1:0] h_addr;
  logic [NSRC-1:0]             serve;
  logic [NSRC-1:0]             ok;

  logic busy, busy_whole, go;
  logic [1:0]        sel_op;
  logic [ADDR_W-1:0] sel_addr;

  assign in_v[SRC_CPU]    = cpu_valid;
  assign in_op[SRC_CPU]   = cpu_op;
  assign in_addr[SRC_CPU] = cpu_addr;
  assign in_v[SRC_DBG]    = dbg_valid;
  assign in_op[SRC_DBG]   = dbg_op;
  assign in_addr[SRC_DBG] = dbg_addr;

  // Fixed priority: processor ahead of debug port, nothing while busy.
  always_comb begin
    serve[SRC_CPU] = !busy && h_v[SRC_CPU];
    serve[SRC_DBG] = !busy && h_v[SRC_DBG] && !h_v[SRC_CPU];
    sel_op   = serve[SRC_CPU] ? h_op[SRC_CPU]   : h_op[SRC_DBG];
    sel_addr = serve[SRC_CPU] ? h_addr[SRC_CPU] : h_addr[SRC_DBG];
    go       = |(serve & ok);
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    fsg_hold #(.AW(ADDR_W)) u_hold (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_v[g]),
      .in_op    (in_op[g]),
      .in_addr  (in_addr[g]),
      .take     (serve[g]),
      .out_valid(h_v[g]),
      .out_op   (h_op[g]),
      .out_addr (h_addr[g])
    );
    fsg_rule #(.PW(PG_W), .IS_DBG(g == SRC_DBG)) u_rule (
      .locked(locked),
      .op    (h_op[g]),
      .page  (h_addr[g][ADDR_W-1:OFS_W]),
      .allow (ok[g])
    );
  end

  fsg_lock u_lock (
    .clk      (clk),
    .rst      (rst),
    .set_req  (lock_set),
    .wipe_done(fc_done && busy && busy_whole),
    .locked   (locked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_grant  <= 1'b0;
      cpu_reject <= 1'b0;
      dbg_grant  <= 1'b0;
      dbg_reject <= 1'b0;
      cpu_viol   <= 1'b0;
      dbg_viol   <= 1'b0;
      fc_start   <= 1'b0;
      fc_op      <= '0;
      fc_addr    <= '0;
      busy       <= 1'b0;
      busy_whole <= 1'b0;
    end else begin
      cpu_grant  <= serve[SRC_CPU] &  ok[SRC_CPU];
      cpu_reject <= serve[SRC_CPU] & ~ok[SRC_CPU];
      dbg_grant  <= serve[SRC_DBG] &  ok[SRC_DBG];
      dbg_reject <= serve[SRC_DBG] & ~ok[SRC_DBG];
      cpu_viol   <= cpu_viol | (serve[SRC_CPU] & ~ok[SRC_CPU]);
      dbg_viol   <= dbg_viol | (serve[SRC_DBG] & ~ok[SRC_DBG]);
      fc_start   <= go;
      if (go) begin
        fc_op      <= sel_op;
        fc_addr    <= sel_addr;
        busy       <= 1'b1;
        busy_whole <= (sel_op == OP_WHOLE);
      end else if (fc_done) begin
        busy       <= 1'b0;
        busy_whole <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fsg_gate_chk.sv
`timescale 1ns/1ps
module fsg_gate_chk #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              lock_set,
  input logic              cpu_grant,
  input logic              cpu_reject,
  input logic              dbg_grant,
  input logic              dbg_reject,
  input logic              cpu_viol,
  input logic              dbg_viol,
  input logic              locked,
  input logic              fc_start,
  input logic [1:0]        fc_op,
  input logic [ADDR_W-1:0] fc_addr,
  input logic              fc_done
);
  import fsg_pkg::*;
  localparam int OFS_W = $clog2(PAGE_BYTES);

  p_one_answer_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_grant, cpu_reject, dbg_grant, dbg_reject}));

  p_cpu_flag_r8: assert property (@(posedge clk) disable iff (rst)
    cpu_reject |-> cpu_viol);

  p_dbg_flag_r8: assert property (@(posedge clk) disable iff (rst)
    dbg_reject |-> dbg_viol);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    ($past(cpu_viol) |-> cpu_viol) and ($past(dbg_viol) |-> dbg_viol));

  p_dbg_whole_only_r2: assert property (@(posedge clk) disable iff (rst)
    (dbg_grant && $past(locked)) |-> (fc_op == OP_WHOLE));

  p_page0_shield_r3: assert property (@(posedge clk) disable iff (rst)
    (fc_start && $past(locked) && fc_op != OP_WHOLE)
      |-> (fc_addr[ADDR_W-1:OFS_W] != '0));

  p_no_rsvd_r11: assert property (@(posedge clk) disable iff (rst)
    fc_start |-> (fc_op != OP_RSVD));

  p_start_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    fc_start |=> !fc_start);

  p_start_has_grant_r12: assert property (@(posedge clk) disable iff (rst)
    fc_start |-> (cpu_grant || dbg_grant));

  p_lock_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(lock_set));

  p_lock_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> ($past(fc_done) && $past(fc_op) == OP_WHOLE));
endmodule

bind flash_sec_gate fsg_gate_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (.*);

// File: tb/flash_sec_gate_bench.sv
`timescale 1ns/1ps
module flash_sec_gate_bench;
  localparam int AW = 12;
  localparam int PB = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_set = 1'b0;
  logic cpu_valid = 1'b0, dbg_valid = 1'b0;
  logic [1:0] cpu_op = '0, dbg_op = '0;
  logic [AW-1:0] cpu_addr = '0, dbg_addr = '0;
  logic cpu_grant, cpu_reject, dbg_grant, dbg_reject, cpu_viol, dbg_viol, locked;
  logic fc_start;
  logic [1:0] fc_op;
  logic [AW-1:0] fc_addr;
  logic fc_done = 1'b0;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  flash_sec_gate #(.ADDR_W(AW), .PAGE_BYTES(PB)) u_flash_sec_gate (
    .clk(clk), .rst(rst), .lock_set(lock_set),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
    .dbg_valid(dbg_valid), .dbg_op(dbg_op), .dbg_addr(dbg_addr),
    .cpu_grant(cpu_grant), .cpu_reject(cpu_reject),
    .dbg_grant(dbg_grant), .dbg_reject(dbg_reject),
    .cpu_viol(cpu_viol), .dbg_viol(dbg_viol), .locked(locked),
    .fc_start(fc_start), .fc_op(fc_op), .fc_addr(fc_addr), .fc_done(fc_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input int act, input int exp);
    chk(act == exp, tag, act, exp);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_lock();
    lock_set = 1'b1;
    @(negedge clk);
    lock_set = 1'b0;
  endtask

  task automatic pulse_done();
    fc_done = 1'b1;
    @(negedge clk);
    fc_done = 1'b0;
  endtask

  task automatic send(input int src, input int op, input int addr);
    if (src == 0) begin
      cpu_valid = 1'b1; cpu_op = 2'(op); cpu_addr = AW'(addr);
    end else begin
      dbg_valid = 1'b1; dbg_op = 2'(op); dbg_addr = AW'(addr);
    end
    @(negedge clk);
    cpu_valid = 1'b0;
    dbg_valid = 1'b0;
  endtask

  function automatic string tag_of(input int s, input int src, input int op);
    if (op == 3) return "R11";
    if (s == 0) return "R1";
    if (op == 2) return "R5";
    if (src == 1) return "R2";
    if (op == 0) return "R3";
    return "R4";
  endfunction

  initial begin
    #2_000_000;
    fails++;
    total++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int addrs[6];
    addrs[0] = 0; addrs[1] = 1; addrs[2] = PB - 1;
    addrs[3] = PB; addrs[4] = PB + 1; addrs[5] = (1 << AW) - 1;

    do_reset();
    // Reset state (R6, R8)
    chk_eq("R6 lock after reset", int'(locked), 0);
    chk_eq("R8 cpu flag after reset", int'(cpu_viol), 0);
    chk_eq("R8 dbg flag after reset", int'(dbg_viol), 0);
    chk_eq("R12 no start after reset", int'(fc_start), 0);

    // Exhaustive sweep: lock state x source x op x boundary address
    for (int s = 0; s < 2; s++)
      for (int src = 0; src < 2; src++)
        for (int op = 0; op < 4; op++)
          for (int ai = 0; ai < 6; ai++) begin
            int a;
            bit pg0, allow;
            string t;
            a = addrs[ai];
            pg0 = (a / PB) == 0;
            allow = (op != 3) &&
                    ((s == 0) || (src == 1 ? op == 2 : !(pg0 && op != 2)));
            t = tag_of(s, src, op);
            do_reset();
            if (s == 1) begin
              pulse_lock();
              chk_eq("R6 lock set", int'(locked), 1);
            end
            send(src, op, a);
            if (src == 0) begin
              chk_eq({t, " cpu grant"}, int'(cpu_grant), int'(allow));
              chk_eq({t, " cpu reject"}, int'(cpu_reject), int'(!allow));
              chk_eq("R8 cpu flag", int'(cpu_viol), int'(!allow));
              chk_eq("R8 dbg quiet", int'(dbg_grant | dbg_reject), 0);
            end else begin
              chk_eq({t, " dbg grant"}, int'(dbg_grant), int'(allow));
              chk_eq({t, " dbg reject"}, int'(dbg_reject), int'(!allow));
              chk_eq("R8 dbg flag", int'(dbg_viol), int'(!allow));
              chk_eq("R8 cpu quiet", int'(cpu_grant | cpu_reject), 0);
            end
            chk_eq("R12 start", int'(fc_start), int'(allow));
            if (allow) begin
              chk_eq("R12 op", int'(fc_op), op);
              chk_eq("R12 addr", int'(fc_addr), a);
              @(negedge clk);
              chk_eq("R12 start one cycle", int'(fc_start), 0);
              pulse_done();
              chk_eq("R5 lock after done", int'(locked), int'(s == 1 && op != 2));
            end else begin
              chk_eq("R6 lock kept after reject", int'(locked), s);
            end
          end

    // Page boundary with the lock set (R7)
    do_reset();
    pulse_lock();
    send(0, 0, PB - 1);
    chk_eq("R7 last byte of page zero", int'(cpu_reject), 1);
    send(0, 0, PB);
    chk_eq("R7 first byte of page one", int'(cpu_grant), 1);
    @(negedge clk);
    pulse_done();

    // Lock is set-only (R6): stays set across time and other traffic
    repeat (5) @(negedge clk);
    chk_eq("R6 lock holds", int'(locked), 1);
    pulse_lock();
    chk_eq("R6 second set", int'(locked), 1);

    // Same-cycle requests (R9) and stall while busy (R10)
    do_reset();
    cpu_valid = 1'b1; cpu_op = 2'd0; cpu_addr = AW'(300);
    dbg_valid = 1'b1; dbg_op = 2'd1; dbg_addr = AW'(700);
    @(negedge clk);
    cpu_valid = 1'b0; dbg_valid = 1'b0;
    chk_eq("R9 cpu first", int'(cpu_grant), 1);
    chk_eq("R9 dbg waits", int'(dbg_grant | dbg_reject), 0);
    chk_eq("R9 cpu addr", int'(fc_addr), 300);
    repeat (3) begin
      @(negedge clk);
      chk_eq("R10 stalled while busy", int'(dbg_grant | dbg_reject | fc_start), 0);
    end
    pulse_done();
    chk_eq("R10 not yet after done", int'(dbg_grant | dbg_reject), 0);
    @(negedge clk);
    chk_eq("R10 held request answered", int'(dbg_grant), 1);
    chk_eq("R9 dbg op kept", int'(fc_op), 1);
    chk_eq("R9 dbg addr kept", int'(fc_addr), 700);
    @(negedge clk);
    pulse_done();

    // Debug whole erase while locked, then lock drops (R5)
    do_reset();
    pulse_lock();
    send(1, 2, 0);
    chk_eq("R5 dbg whole granted", int'(dbg_grant), 1);
    chk_eq("R5 lock still set while busy", int'(locked), 1);
    pulse_done();
    chk_eq("R5 lock cleared", int'(locked), 0);
    send(1, 0, 0);
    chk_eq("R1 open after wipe", int'(dbg_grant), 1);
    @(negedge clk);
    pulse_done();

    // Sticky flag survives later grants (R8)
    do_reset();
    send(0, 3, 5);
    chk_eq("R11 rsvd reject", int'(cpu_reject), 1);
    send(0, 0, 5);
    @(negedge clk);
    pulse_done();
    chk_eq("R8 flag sticky", int'(cpu_viol), 1);
    chk_eq("R8 other flag clear", int'(dbg_viol), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule